// File: doc/BRIEF.md
# Power-State Request Dispatcher

The dispatcher sits between the host's device power-state requests and two downstream sequencers: one that fully powers a device rail set up or down, and one that moves the device into or out of a low-power retention state while keeping its rails partly alive. A D3 request turns into a full power-off, a retention entry, or nothing. The choice depends on a defer enable and an entry code that the host programs beforehand. A D0 request turns into a full power-on, a retention exit, or nothing, chosen the same way with an exit code.

D3 handling is one-shot. The host must arm a power-control enable before each D3, and finishing the D3 disarms it. Finishing a D3 also sets a wake-pending flag, and only that flag lets a later D0 act. So the wake path runs only after the sleep path really ran. When firmware owns the device's configuration space, the dispatcher pulses a save strobe before the D3 start and a restore strobe before the D0 start, for an external configuration buffer. While a sequence runs, the dispatcher is busy, ignores new requests and drops host register writes.

Top module: `pwr_req_dispatch`

## Requirements
- R1: A D3 request is accepted only when the power-control enable is 1 and the block is idle. Otherwise it has no effect: no strobe, busy stays low, and no flag changes.
- R2: If `fw_owns_cfg_i` is high when a request is accepted, a one-cycle `cfg_save_o` (D3) or `cfg_restore_o` (D0) pulse appears in the first busy cycle, and the start strobe follows in the next cycle. With the input low there is no save or restore pulse, and the start strobe appears in the first busy cycle.
- R3: On an accepted D3 with defer enabled, retention entry starts only if the entry code is 1 or 2. Any other code starts nothing. With defer disabled, full power-off starts.
- R4: When a D3 sequence completes, wake-pending becomes 1 and the power-control enable becomes 0. The defer enable is unchanged.
- R5: A D0 request is accepted only when wake-pending is 1 and the block is idle. Otherwise it has no effect, and in particular the defer enable is not cleared.
- R6: On an accepted D0 with defer enabled, retention exit starts only if the exit code is 3, and the defer enable is cleared whether or not it started. With defer disabled, full power-on starts.
- R7: When a D0 sequence completes, wake-pending becomes 0.
- R8: A host write (`wr_i`) lands only while busy is low. Address 0 sets the power-control enable (data bit 0), 1 sets the defer enable (data bit 0), 2 sets the entry code and 3 sets the exit code. A write in the same cycle a request is accepted lands, but the request's choice uses the values from before the write.
- R9: Busy rises in the cycle after acceptance. It stays high until the cycle after the selected sequencer's done pulse, or for one cycle after the start slot when nothing was started. A done pulse from the other sequencer, or one arriving in the start cycle, is ignored. Each sequence gives at most one one-cycle start strobe, and everything resets to zero.
- R10: If a qualifying D3 and a qualifying D0 arrive in the same cycle, the D3 is served and the D0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 2 | Host register address |
| wr_data_i | input | CODE_W | Host write data |
| fw_owns_cfg_i | input | 1 | Firmware owns configuration space |
| d3_req_i | input | 1 | D3 request pulse |
| d0_req_i | input | 1 | D0 request pulse |
| full_done_i | input | 1 | Full-power sequencer finished |
| ret_done_i | input | 1 | Retention sequencer finished |
| busy_o | output | 1 | Sequence in progress |
| cfg_save_o | output | 1 | Save configuration space strobe |
| cfg_restore_o | output | 1 | Restore configuration space strobe |
| full_off_start_o | output | 1 | Start full power-off |
| full_on_start_o | output | 1 | Start full power-on |
| ret_entry_start_o | output | 1 | Start retention entry |
| ret_exit_start_o | output | 1 | Start retention exit |
| ctl_en_o | output | 1 | Power-control enable state |
| wake_pend_o | output | 1 | Wake-pending flag state |
| defer_en_o | output | 1 | Defer enable state |

## Verification
Two pairs of functions can share one clock cycle. The first pair is a host write and the acceptance of a request. The bench provokes it by raising a D0 request together with a write that changes the exit code. It expects the retention exit chosen from the old code, and then shows through a later D0 that the new code did land. The second pair is a D3 request and a D0 request that both qualify. The bench raises them together and judges the outcome by the strobe that appears and by the flags afterwards: wake-pending stays set, the enable drops, and defer survives.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CFG, ST_LAUNCH, ST_WAIT} state_e;
  typedef enum logic [1:0] {TGT_NONE, TGT_FULL, TGT_RET} tgt_e;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTL_EN = 2'd0;
  localparam logic [ADDR_W-1:0] A_DEFER  = 2'd1;
  localparam logic [ADDR_W-1:0] A_ENTRY  = 2'd2;
  localparam logic [ADDR_W-1:0] A_EXIT   = 2'd3;
endpackage

// File: rtl/pwr_req_regs.sv
module pwr_req_regs
  import pwr_req_pkg::*;
#(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  input  logic              fin_i,
  input  logic              fin_d3_i,
  input  logic              fin_clr_defer_i,
  output logic              ctl_en_o,
  output logic              wake_o,
  output logic              defer_o,
  output logic [CODE_W-1:0] entry_code_o,
  output logic [CODE_W-1:0] exit_code_o
);
  logic we;
  assign we = wr_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_en_o     <= 1'b0;
      wake_o       <= 1'b0;
      defer_o      <= 1'b0;
      entry_code_o <= '0;
      exit_code_o  <= '0;
    end else begin
      if (we) begin
        unique case (wr_addr_i)
          A_CTL_EN: ctl_en_o     <= wr_data_i[0];
          A_DEFER:  defer_o      <= wr_data_i[0];
          A_ENTRY:  entry_code_o <= wr_data_i;
          A_EXIT:   exit_code_o  <= wr_data_i;
          default:  ;
        endcase
      end
      // completion only happens while busy, so it never meets a write
      if (fin_i) begin
        if (fin_d3_i) begin
          wake_o   <= 1'b1;
          ctl_en_o <= 1'b0;
        end else begin
          wake_o <= 1'b0;
          if (fin_clr_defer_i) defer_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pwr_req_select.sv
module pwr_req_select
  import pwr_req_pkg::*;
#(
  parameter int unsigned               CODE_W        = 4,
  parameter int unsigned               N_ENTRY_OK    = 2,
  parameter logic [N_ENTRY_OK*CODE_W-1:0] ENTRY_OK_LIST = {4'd2, 4'd1},
  parameter logic [CODE_W-1:0]         EXIT_OK       = 4'd3
) (
  input  logic              busy_i,
  input  logic              d3_req_i,
  input  logic              d0_req_i,
  input  logic              ctl_en_i,
  input  logic              wake_i,
  input  logic              defer_i,
  input  logic [CODE_W-1:0] entry_code_i,
  input  logic [CODE_W-1:0] exit_code_i,
  output logic              accept_o,
  output logic              acc_d3_o,
  output tgt_e              tgt_o
);
  logic [N_ENTRY_OK-1:0] hit_vec;
  logic entry_hit, exit_hit, d3_ok, d0_ok;

  for (genvar i = 0; i < N_ENTRY_OK; i++) begin : g_entry_cmp
    assign hit_vec[i] = (entry_code_i == ENTRY_OK_LIST[i*CODE_W +: CODE_W]);
  end

  assign entry_hit = |hit_vec;
  assign exit_hit  = (exit_code_i == EXIT_OK);
  assign d3_ok     = d3_req_i & ctl_en_i;
  assign d0_ok     = d0_req_i & wake_i;
  assign accept_o  = ~busy_i & (d3_ok | d0_ok);
  assign acc_d3_o  = d3_ok;  // D3 wins a tie

  always_comb begin
    if (!defer_i)   tgt_o = TGT_FULL;
    else if (d3_ok) tgt_o = entry_hit ? TGT_RET : TGT_NONE;
    else            tgt_o = exit_hit ? TGT_RET : TGT_NONE;
  end
endmodule

// File: rtl/pwr_req_fsm.sv
module pwr_req_fsm
  import pwr_req_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic acc_d3_i,
  input  tgt_e tgt_i,
  input  logic defer_i,
  input  logic fw_owns_i,
  input  logic full_done_i,
  input  logic ret_done_i,
  output logic busy_o,
  output logic save_o,
  output logic restore_o,
  output logic full_off_start_o,
  output logic full_on_start_o,
  output logic ret_entry_start_o,
  output logic ret_exit_start_o,
  output logic fin_o,
  output logic fin_d3_o,
  output logic fin_clr_defer_o
);
  state_e state_q;
  tgt_e   tgt_q;
  logic   op_d3_q, clr_def_q, done_sel, launch;

  assign done_sel = (tgt_q == TGT_FULL) ? full_done_i : ret_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tgt_q     <= TGT_NONE;
      op_d3_q   <= 1'b0;
      clr_def_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_i) begin
          op_d3_q   <= acc_d3_i;
          tgt_q     <= tgt_i;
          clr_def_q <= ~acc_d3_i & defer_i;
          state_q   <= fw_owns_i ? ST_CFG : ST_LAUNCH;
        end
        ST_CFG:    state_q <= ST_LAUNCH;
        ST_LAUNCH: state_q <= (tgt_q == TGT_NONE) ? ST_IDLE : ST_WAIT;
        ST_WAIT:   if (done_sel) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign launch            = (state_q == ST_LAUNCH);
  assign busy_o            = (state_q != ST_IDLE);
  assign save_o            = (state_q == ST_CFG) & op_d3_q;
  assign restore_o         = (state_q == ST_CFG) & ~op_d3_q;
  assign full_off_start_o  = launch & op_d3_q & (tgt_q == TGT_FULL);
  assign full_on_start_o   = launch & ~op_d3_q & (tgt_q == TGT_FULL);
  assign ret_entry_start_o = launch & op_d3_q & (tgt_q == TGT_RET);
  assign ret_exit_start_o  = launch & ~op_d3_q & (tgt_q == TGT_RET);
  assign fin_o             = (launch & (tgt_q == TGT_NONE)) |
                             ((state_q == ST_WAIT) & done_sel);
  assign fin_d3_o          = op_d3_q;
  assign fin_clr_defer_o   = clr_def_q;
endmodule

// File: rtl/pwr_req_dispatch.sv
module pwr_req_dispatch
  import pwr_req_pkg::*;
#(
  parameter int unsigned                  CODE_W        = 4,
  parameter int unsigned                  N_ENTRY_OK    = 2,
  parameter logic [N_ENTRY_OK*CODE_W-1:0] ENTRY_OK_LIST = {4'd2, 4'd1},
  parameter logic [CODE_W-1:0]            EXIT_OK       = 4'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  input  logic              fw_owns_cfg_i,
  input  logic              d3_req_i,
  input  logic              d0_req_i,
  input  logic              full_done_i,
  input  logic              ret_done_i,
  output logic              busy_o,
  output logic              cfg_save_o,
  output logic              cfg_restore_o,
  output logic              full_off_start_o,
  output logic              full_on_start_o,
  output logic              ret_entry_start_o,
  output logic              ret_exit_start_o,
  output logic              ctl_en_o,
  output logic              wake_pend_o,
  output logic              defer_en_o
);
  logic              accept, acc_d3, fin, fin_d3, fin_clr_defer;
  logic [CODE_W-1:0] entry_code, exit_code;
  tgt_e              tgt;

  pwr_req_regs #(.CODE_W(CODE_W)) u_regs (
    .clk_i, .rst_ni, .wr_i,
    .busy_i          (busy_o),
    .wr_addr_i, .wr_data_i,
    .fin_i           (fin),
    .fin_d3_i        (fin_d3),
    .fin_clr_defer_i (fin_clr_defer),
    .ctl_en_o        (ctl_en_o),
    .wake_o          (wake_pend_o),
    .defer_o         (defer_en_o),
    .entry_code_o    (entry_code),
    .exit_code_o     (exit_code)
  );

  pwr_req_select #(
    .CODE_W(CODE_W), .N_ENTRY_OK(N_ENTRY_OK),
    .ENTRY_OK_LIST(ENTRY_OK_LIST), .EXIT_OK(EXIT_OK)
  ) u_sel (
    .busy_i       (busy_o),
    .d3_req_i, .d0_req_i,
    .ctl_en_i     (ctl_en_o),
    .wake_i       (wake_pend_o),
    .defer_i      (defer_en_o),
    .entry_code_i (entry_code),
    .exit_code_i  (exit_code),
    .accept_o     (accept),
    .acc_d3_o     (acc_d3),
    .tgt_o        (tgt)
  );

  pwr_req_fsm u_fsm (
    .clk_i, .rst_ni,
    .accept_i          (accept),
    .acc_d3_i          (acc_d3),
    .tgt_i             (tgt),
    .defer_i           (defer_en_o),
    .fw_owns_i         (fw_owns_cfg_i),
    .full_done_i, .ret_done_i,
    .busy_o            (busy_o),
    .save_o            (cfg_save_o),
    .restore_o         (cfg_restore_o),
    .full_off_start_o, .full_on_start_o,
    .ret_entry_start_o, .ret_exit_start_o,
    .fin_o             (fin),
    .fin_d3_o          (fin_d3),
    .fin_clr_defer_o   (fin_clr_defer)
  );
endmodule

// File: rtl/pwr_req_dispatch_chk.sv
module pwr_req_dispatch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic d3_req_i,
  input logic d0_req_i,
  input logic busy_o,
  input logic cfg_save_o,
  input logic cfg_restore_o,
  input logic full_off_start_o,
  input logic full_on_start_o,
  input logic ret_entry_start_o,
  input logic ret_exit_start_o,
  input logic ctl_en_o,
  input logic wake_pend_o,
  input logic defer_en_o
);
  logic [3:0] starts;
  assign starts = {full_off_start_o, full_on_start_o, ret_entry_start_o, ret_exit_start_o};

  AST_START_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(starts)); // R9
  AST_STRB_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|starts) || cfg_save_o || cfg_restore_o) |-> busy_o); // R9
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|starts) |=> !(|starts)); // R9
  AST_SAVE_REST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_save_o && cfg_restore_o)); // R2
  AST_SAVE_THEN_D3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_save_o |=> !(full_on_start_o || ret_exit_start_o)); // R2
  AST_REST_THEN_D0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_restore_o |=> !(full_off_start_o || ret_entry_start_o)); // R2
  AST_D3_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && d3_req_i && ctl_en_o) |=> busy_o); // R1
  AST_D3_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && d3_req_i && !ctl_en_o && !(d0_req_i && wake_pend_o)) |=> !busy_o); // R1
  AST_D0_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && d0_req_i && !wake_pend_o && !(d3_req_i && ctl_en_o)) |=> !busy_o); // R5
  AST_WAKE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_pend_o) |-> (!ctl_en_o && $fell(busy_o))); // R4
  AST_WAKE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wake_pend_o) |-> $fell(busy_o)); // R7
  AST_REGS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(ctl_en_o) && $stable(defer_en_o))); // R8
  AST_DEFER_SET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(defer_en_o) |-> !$past(busy_o)); // R8
endmodule

bind pwr_req_dispatch pwr_req_dispatch_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .d3_req_i          (d3_req_i),
  .d0_req_i          (d0_req_i),
  .busy_o            (busy_o),
  .cfg_save_o        (cfg_save_o),
  .cfg_restore_o     (cfg_restore_o),
  .full_off_start_o  (full_off_start_o),
  .full_on_start_o   (full_on_start_o),
  .ret_entry_start_o (ret_entry_start_o),
  .ret_exit_start_o  (ret_exit_start_o),
  .ctl_en_o          (ctl_en_o),
  .wake_pend_o       (wake_pend_o),
  .defer_en_o        (defer_en_o)
);

// File: tb/pwr_req_dispatch_tb_top.sv
module pwr_req_dispatch_tb_top;
  localparam int CODE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [CODE_W-1:0] wr_data = '0;
  logic fw_owns = 1'b0, d3_req = 1'b0, d0_req = 1'b0, full_done = 1'b0, ret_done = 1'b0;
  logic busy_o, cfg_save_o, cfg_restore_o, full_off_start_o, full_on_start_o;
  logic ret_entry_start_o, ret_exit_start_o, ctl_en_o, wake_pend_o, defer_en_o;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pwr_req_dispatch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .fw_owns_cfg_i(fw_owns), .d3_req_i(d3_req), .d0_req_i(d0_req),
    .full_done_i(full_done), .ret_done_i(ret_done), .busy_o(busy_o),
    .cfg_save_o(cfg_save_o), .cfg_restore_o(cfg_restore_o),
    .full_off_start_o(full_off_start_o), .full_on_start_o(full_on_start_o),
    .ret_entry_start_o(ret_entry_start_o), .ret_exit_start_o(ret_exit_start_o),
    .ctl_en_o(ctl_en_o), .wake_pend_o(wake_pend_o), .defer_en_o(defer_en_o)
  );

  // start ids: 0 none, 1 full off, 2 full on, 3 retention entry, 4 retention exit
  typedef struct packed {
    logic       op_d3;
    logic       fw;
    logic       defer;
    logic [3:0] ent;
    logic [3:0] ext;
    logic       exp_save;
    logic       exp_rest;
    logic [2:0] exp_start;
    logic       exp_defer;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b0, 4'd0, 4'd0, 1'b1, 1'b0, 3'd1, 1'b0}, // R3 full off, R2 save
    '{1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd2, 1'b0}, // R6 full on, R2 restore
    '{1'b1, 1'b0, 1'b1, 4'd1, 4'd0, 1'b0, 1'b0, 3'd3, 1'b1}, // R3 code 1
    '{1'b0, 1'b0, 1'b1, 4'd0, 4'd3, 1'b0, 1'b0, 3'd4, 1'b0}, // R6 code 3
    '{1'b1, 1'b1, 1'b1, 4'd2, 4'd0, 1'b1, 1'b0, 3'd3, 1'b1}, // R3 code 2
    '{1'b0, 1'b0, 1'b1, 4'd0, 4'd2, 1'b0, 1'b0, 3'd0, 1'b0}, // R6 bad exit, defer still cleared
    '{1'b1, 1'b0, 1'b1, 4'd7, 4'd0, 1'b0, 1'b0, 3'd0, 1'b1}, // R3 bad entry
    '{1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd2, 1'b0}  // R6 full on
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cur_start();
    if (full_off_start_o) return 1;
    if (full_on_start_o) return 2;
    if (ret_entry_start_o) return 3;
    if (ret_exit_start_o) return 4;
    return 0;
  endfunction

  task automatic write_reg(input logic [1:0] a, input logic [CODE_W-1:0] d);
    @(negedge clk);
    wr = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_req(input bit d3, input bit d0, input bit fw, input bit exp_save,
                        input bit exp_rest, input int exp_start, input string tag);
    int save_c, rest_c, start_id, busy_c, done_at, n_start, exp_busy;
    save_c = -1; rest_c = -1; start_id = 0; busy_c = 0; done_at = -1; n_start = 0;
    @(negedge clk);
    fw_owns = fw; d3_req = d3; d0_req = d0;
    @(negedge clk);
    d3_req = 1'b0; d0_req = 1'b0;
    for (int k = 1; k <= 30; k++) begin
      full_done = 1'b0; ret_done = 1'b0;
      if (!busy_o) break;
      busy_c++;
      if (cfg_save_o) save_c = k;
      if (cfg_restore_o) rest_c = k;
      if (cur_start() != 0) begin
        n_start++; start_id = cur_start(); done_at = k + 2;
      end
      if (k == done_at) begin
        if (start_id <= 2) full_done = 1'b1; else ret_done = 1'b1;
      end
      @(negedge clk);
    end
    full_done = 1'b0; ret_done = 1'b0;
    exp_busy = (exp_start == 0) ? (fw ? 2 : 1) : (fw ? 4 : 3);
    chk(start_id == exp_start && n_start <= 1, tag, start_id, exp_start);
    chk(save_c == (exp_save ? 1 : -1), "R2 save cycle", save_c, exp_save ? 1 : -1);
    chk(rest_c == (exp_rest ? 1 : -1), "R2 restore cycle", rest_c, exp_rest ? 1 : -1);
    chk(busy_c == exp_busy, "R9 busy length", busy_c, exp_busy);
  endtask

  task automatic run_vec(input vec_t v);
    write_reg(2'd1, {3'b0, v.defer});
    write_reg(2'd2, v.ent);
    write_reg(2'd3, v.ext);
    if (v.op_d3) write_reg(2'd0, 4'd1);
    do_req(v.op_d3, !v.op_d3, v.fw, v.exp_save, v.exp_rest, int'(v.exp_start),
           v.op_d3 ? "R3 start select" : "R6 start select");
    chk(wake_pend_o == v.op_d3, v.op_d3 ? "R4 wake set" : "R7 wake cleared",
        wake_pend_o, v.op_d3);
    chk(ctl_en_o == 1'b0, "R4 enable cleared", ctl_en_o, 0);
    chk(defer_en_o == v.exp_defer, v.op_d3 ? "R4 defer kept" : "R6 defer cleared",
        defer_en_o, v.exp_defer);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R9)
    chk(busy_o == 0 && cur_start() == 0 && !cfg_save_o && !cfg_restore_o,
        "R9 reset outputs", busy_o, 0);
    chk({ctl_en_o, wake_pend_o, defer_en_o} == 3'b000, "R9 reset flags",
        {ctl_en_o, wake_pend_o, defer_en_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: D3 with enable low is ignored
    @(negedge clk); d3_req = 1'b1; fw_owns = 1'b1;
    @(negedge clk); d3_req = 1'b0;
    chk(!busy_o && !cfg_save_o && cur_start() == 0, "R1 D3 ignored", busy_o, 0);
    @(negedge clk);
    chk(!busy_o && !wake_pend_o, "R1 D3 ignored flags", wake_pend_o, 0);

    // R5: D0 without wake-pending is ignored, defer not cleared
    write_reg(2'd1, 4'd1);
    @(negedge clk); d0_req = 1'b1;
    @(negedge clk); d0_req = 1'b0;
    chk(!busy_o && !cfg_restore_o && cur_start() == 0, "R5 D0 ignored", busy_o, 0);
    @(negedge clk);
    chk(defer_en_o == 1'b1, "R5 defer kept", defer_en_o, 1);

    // R8 write while busy dropped; R9 foreign and early done ignored
    write_reg(2'd1, 4'd0);
    write_reg(2'd0, 4'd1);
    @(negedge clk); fw_owns = 1'b0; d3_req = 1'b1;
    @(negedge clk); d3_req = 1'b0;
    chk(full_off_start_o == 1'b1, "R3 full off", cur_start(), 1);
    wr = 1'b1; wr_addr = 2'd1; wr_data = 4'd1; full_done = 1'b1;
    @(negedge clk); wr = 1'b0; full_done = 1'b0; ret_done = 1'b1;
    chk(busy_o == 1'b1, "R9 done in start cycle ignored", busy_o, 1);
    @(negedge clk); ret_done = 1'b0;
    chk(busy_o == 1'b1, "R9 foreign done ignored", busy_o, 1);
    full_done = 1'b1;
    @(negedge clk); full_done = 1'b0;
    chk(!busy_o && wake_pend_o, "R9 completion", busy_o, 0);
    chk(defer_en_o == 1'b0, "R8 busy write dropped", defer_en_o, 0);

    // R10: D3 and D0 together, D3 served
    write_reg(2'd0, 4'd1);
    write_reg(2'd1, 4'd1);
    write_reg(2'd2, 4'd1);
    write_reg(2'd3, 4'd3);
    do_req(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3, "R10 D3 wins");
    chk(wake_pend_o && !ctl_en_o && defer_en_o, "R10 flags after tie",
        {wake_pend_o, ctl_en_o, defer_en_o}, 3'b101);

    // R8: write in the acceptance cycle lands, choice uses old code
    @(negedge clk); d0_req = 1'b1; wr = 1'b1; wr_addr = 2'd3; wr_data = 4'd5;
    @(negedge clk); d0_req = 1'b0; wr = 1'b0;
    chk(ret_exit_start_o == 1'b1, "R8 old exit code used", cur_start(), 4);
    @(negedge clk); ret_done = 1'b1;
    @(negedge clk); ret_done = 1'b0;
    chk(!busy_o && !wake_pend_o && !defer_en_o, "R6 exit done flags",
        {busy_o, wake_pend_o, defer_en_o}, 0);
    write_reg(2'd1, 4'd1);
    write_reg(2'd0, 4'd1);
    do_req(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3, "R3 entry again");
    do_req(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R8 new exit code landed");
    chk(defer_en_o == 1'b0, "R6 defer cleared on no-op", defer_en_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule